// File: doc/BRIEF.md
# OLED Panel Power and Initialization Sequencer

This block sits on the controller side of a 128x64 monochrome OLED driver. It takes the panel from power-off to a running display, and back down again, in an order that protects the panel. It drives the panel's active-low reset line and the enable of the panel high-voltage supply. It also produces a byte stream of commands and display-RAM data, with a flag that tells the two apart. A separate serial or parallel transport carries that stream to the driver over a valid/ready handshake. The transport's bus timing is not part of this block.

A power-up request starts a fixed sequence:

1. A timed reset pulse.
2. A display-off command, followed by a fixed configuration table. A strap input, sampled when the request is accepted, selects one of two tables: internal charge pump or external high-voltage supply.
3. Addressing of column 0 / page 0, followed by a full pass of zero bytes into display RAM.
4. Enabling of the high-voltage supply (external mode only) and a settle wait.
5. The display-on command.

A shutdown request sends display-off, drops the supply, waits for the panel to discharge, and then reports that the logic supply may be removed. All delays derive from a clock-frequency parameter.

Top module: `oled_pwr_seq`

## Requirements
- R1: After synchronous reset, `state_code` is 0 (idle-off), `panel_rst_n` is low, `hv_supply_en` is low and `tx_valid` is low. The `state_code` encoding is: 0 idle-off, 1 busy, 2 on, 3 shutdown-done.
- R2: `power_up_req` is accepted only when `state_code` is 0 or 3. After acceptance, `panel_rst_n` stays low for RESET_MS*CLK_HZ/1000 further cycles and then goes high. It rises exactly that many cycles plus one after the cycle in which the request is presented. No byte is offered while `panel_rst_n` is low.
- R3: The first 22 bytes after reset release are commands (`tx_is_data` = 0). With `ext_hv_mode` = 0 they are AE 00 10 40 81 CF A1 A6 A8 3F D3 00 D5 80 D9 F1 DA 12 DB 40 8D 14 (hex). With `ext_hv_mode` = 1 the contrast value CF becomes 8F, the pre-charge value F1 becomes 22, and the pump argument 14 becomes 10.
- R4: Next come the commands 00, 10, B0 (column 0 low nibble, column 0 high nibble, page 0). They are followed by COLUMNS*PAGES (1024) data bytes of value 00 with `tx_is_data` = 1.
- R5: A byte is transferred only on a cycle with `tx_valid` and `tx_ready` both high. While `tx_ready` is low, `tx_valid`, `tx_byte` and `tx_is_data` hold unchanged.
- R6: In external mode, `hv_supply_en` rises in the cycle after the last RAM byte is transferred, and display-on (AF) is offered no sooner than SETTLE_MS*CLK_HZ/1000 cycles later. In charge-pump mode, `hv_supply_en` stays low throughout and the same wait separates the last RAM byte from AF.
- R7: After AF (a command) is transferred, `state_code` becomes 2. `panel_rst_n` stays high, and `hv_supply_en` stays high only in external mode.
- R8: `power_down_req` in state 2 sends one AE command. `hv_supply_en` then goes low in the cycle after that transfer. After the settle wait, `state_code` becomes 3 with `panel_rst_n` low and `hv_supply_en` low.
- R9: `power_down_req` outside state 2 and `power_up_req` outside states 0 and 3 are ignored: no byte is offered and the sequence is unaltered.
- R10: The strap is captured when power-up is accepted. Later changes of `ext_hv_mode` alter neither the table nor the supply enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| power_up_req | input | 1 | Request to bring the panel up |
| power_down_req | input | 1 | Request to shut the panel down |
| ext_hv_mode | input | 1 | Strap: 1 external high-voltage supply, 0 internal charge pump |
| panel_rst_n | output | 1 | Active-low reset to the panel driver |
| hv_supply_en | output | 1 | Enable for the external high-voltage supply |
| tx_valid | output | 1 | Byte offered to the transport |
| tx_ready | input | 1 | Transport accepts the offered byte |
| tx_byte | output | 8 | Command or data byte |
| tx_is_data | output | 1 | 1 display RAM data, 0 command |
| state_code | output | 2 | 0 idle-off, 1 busy, 2 on, 3 shutdown-done |

## Verification
The bench builds the block with CLK_HZ = 10000, which gives ten cycles per millisecond. The 10 ms reset pulse therefore becomes 100 cycles and each 100 ms settle wait becomes 1000 cycles. This lets several complete power-up and shutdown cycles, in both supply modes and with random transport back-pressure, fit in a short run. COLUMNS and PAGES keep their defaults of 128 and 8, so the full 1024-byte RAM clear and the counter wrap at its end are exercised at real size.

// File: rtl/oled_seq_pkg.sv
package oled_seq_pkg;

    typedef enum logic [3:0] {
        ST_OFF,
        ST_RST,
        ST_INIT,
        ST_ADDR,
        ST_CLEAR,
        ST_HVWAIT,
        ST_DISPON,
        ST_ON,
        ST_DISPOFF,
        ST_DRAIN,
        ST_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        STAT_IDLE = 2'd0,
        STAT_BUSY = 2'd1,
        STAT_ON   = 2'd2,
        STAT_DONE = 2'd3
    } seq_status_e;

    typedef struct packed {
        logic       valid;
        logic       is_data;
        logic [7:0] val;
    } tx_beat_t;

    localparam int INIT_LEN = 22;
    localparam int ADDR_LEN = 3;

    localparam logic [7:0] CMD_PANEL_ON  = 8'hAF;
    localparam logic [7:0] CMD_PANEL_OFF = 8'hAE;

    // configuration bytes sent after reset; ext selects the external-supply variant
    function automatic logic [7:0] init_cmd(input int i, input logic ext);
        logic [7:0] b;
        case (i)
            0:  b = 8'hAE;
            1:  b = 8'h00;
            2:  b = 8'h10;
            3:  b = 8'h40;
            4:  b = 8'h81;
            5:  b = ext ? 8'h8F : 8'hCF;
            6:  b = 8'hA1;
            7:  b = 8'hA6;
            8:  b = 8'hA8;
            9:  b = 8'h3F;
            10: b = 8'hD3;
            11: b = 8'h00;
            12: b = 8'hD5;
            13: b = 8'h80;
            14: b = 8'hD9;
            15: b = ext ? 8'h22 : 8'hF1;
            16: b = 8'hDA;
            17: b = 8'h12;
            18: b = 8'hDB;
            19: b = 8'h40;
            20: b = 8'h8D;
            21: b = ext ? 8'h10 : 8'h14;
            default: b = 8'hE3;
        endcase
        return b;
    endfunction

    // column 0 low nibble, column 0 high nibble, page 0
    function automatic logic [7:0] addr_cmd(input int i);
        logic [7:0] b;
        case (i)
            0:       b = 8'h00;
            1:       b = 8'h10;
            default: b = 8'hB0;
        endcase
        return b;
    endfunction

    function automatic seq_status_e status_of(input seq_state_e s);
        seq_status_e r;
        case (s)
            ST_OFF:  r = STAT_IDLE;
            ST_ON:   r = STAT_ON;
            ST_DONE: r = STAT_DONE;
            default: r = STAT_BUSY;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/oled_ms_timer.sv
module oled_ms_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/oled_step_cnt.sv
module oled_step_cnt #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic [W-1:0] limit,
    output logic [W-1:0] cnt,
    output logic         last
);
    assign last = (cnt == limit - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= last ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/oled_pwr_seq.sv
module oled_pwr_seq
    import oled_seq_pkg::*;
#(
    parameter int CLK_HZ    = 100_000_000,
    parameter int RESET_MS  = 10,
    parameter int SETTLE_MS = 100,
    parameter int COLUMNS   = 128,
    parameter int PAGES     = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       power_up_req,
    input  logic       power_down_req,
    input  logic       ext_hv_mode,
    output logic       panel_rst_n,
    output logic       hv_supply_en,
    output logic       tx_valid,
    input  logic       tx_ready,
    output logic [7:0] tx_byte,
    output logic       tx_is_data,
    output logic [1:0] state_code
);
    localparam int TICKS_MS     = CLK_HZ / 1000;
    localparam int RST_TICKS    = TICKS_MS * RESET_MS;
    localparam int SETTLE_TICKS = TICKS_MS * SETTLE_MS;
    localparam int MAX_TICKS    = (RST_TICKS > SETTLE_TICKS) ? RST_TICKS : SETTLE_TICKS;
    localparam int TMR_W        = $clog2(MAX_TICKS + 1);
    localparam int CLEAR_BYTES  = COLUMNS * PAGES;
    localparam int IDX_RAW      = $clog2(CLEAR_BYTES + 1);
    localparam int IDX_W        = (IDX_RAW > 5) ? IDX_RAW : 5;

    localparam logic [TMR_W-1:0] RST_LOAD    = TMR_W'(RST_TICKS - 1);
    localparam logic [TMR_W-1:0] SETTLE_LOAD = TMR_W'(SETTLE_TICKS - 1);

    seq_state_e        state, state_nx;
    logic              ext_q;
    logic              tmr_load, tmr_zero;
    logic [TMR_W-1:0]  tmr_val;
    logic [IDX_W-1:0]  idx, idx_limit;
    logic              idx_last;
    logic              xfer;
    logic              start_ok;
    tx_beat_t          beat;

    oled_ms_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    oled_step_cnt #(.W(IDX_W)) u_step (
        .clk   (clk),
        .rst   (rst),
        .inc   (xfer),
        .limit (idx_limit),
        .cnt   (idx),
        .last  (idx_last)
    );

    // byte length of the stream phase the sequencer is in
    always_comb begin
        case (state)
            ST_INIT:  idx_limit = IDX_W'(INIT_LEN);
            ST_ADDR:  idx_limit = IDX_W'(ADDR_LEN);
            ST_CLEAR: idx_limit = IDX_W'(CLEAR_BYTES);
            default:  idx_limit = IDX_W'(1);
        endcase
    end

    // byte offered to the transport
    always_comb begin
        beat = '0;
        case (state)
            ST_INIT:    beat = '{valid: 1'b1, is_data: 1'b0, val: init_cmd(int'(idx), ext_q)};
            ST_ADDR:    beat = '{valid: 1'b1, is_data: 1'b0, val: addr_cmd(int'(idx))};
            ST_CLEAR:   beat = '{valid: 1'b1, is_data: 1'b1, val: 8'h00};
            ST_DISPON:  beat = '{valid: 1'b1, is_data: 1'b0, val: CMD_PANEL_ON};
            ST_DISPOFF: beat = '{valid: 1'b1, is_data: 1'b0, val: CMD_PANEL_OFF};
            default:    beat = '0;
        endcase
    end

    assign xfer     = beat.valid & tx_ready;
    assign start_ok = power_up_req & ((state == ST_OFF) | (state == ST_DONE));

    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        tmr_val  = SETTLE_LOAD;
        case (state)
            ST_OFF, ST_DONE: begin
                if (start_ok) begin
                    state_nx = ST_RST;
                    tmr_load = 1'b1;
                    tmr_val  = RST_LOAD;
                end
            end
            ST_RST:   if (tmr_zero) state_nx = ST_INIT;
            ST_INIT:  if (xfer && idx_last) state_nx = ST_ADDR;
            ST_ADDR:  if (xfer && idx_last) state_nx = ST_CLEAR;
            ST_CLEAR: begin
                if (xfer && idx_last) begin
                    state_nx = ST_HVWAIT;
                    tmr_load = 1'b1;
                end
            end
            ST_HVWAIT: if (tmr_zero) state_nx = ST_DISPON;
            ST_DISPON: if (xfer) state_nx = ST_ON;
            ST_ON:     if (power_down_req) state_nx = ST_DISPOFF;
            ST_DISPOFF: begin
                if (xfer) begin
                    state_nx = ST_DRAIN;
                    tmr_load = 1'b1;
                end
            end
            ST_DRAIN: if (tmr_zero) state_nx = ST_DONE;
            default:  state_nx = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_OFF;
            ext_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (start_ok) begin
                ext_q <= ext_hv_mode;
            end
        end
    end

    assign tx_valid     = beat.valid;
    assign tx_byte      = beat.val;
    assign tx_is_data   = beat.is_data;
    assign panel_rst_n  = !((state == ST_OFF) || (state == ST_RST) || (state == ST_DONE));
    assign hv_supply_en = ext_q && ((state == ST_HVWAIT) || (state == ST_DISPON) ||
                                    (state == ST_ON) || (state == ST_DISPOFF));
    assign state_code   = status_of(state);

    AST_NO_TX_IN_RESET: assert property (@(posedge clk) disable iff (rst)
        !panel_rst_n |-> !tx_valid); // R2

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte) && $stable(tx_is_data))); // R5

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_is_data) |-> (tx_byte == 8'h00)); // R4

    AST_HV_AFTER_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $rose(hv_supply_en) |-> ($past(state) == ST_CLEAR)); // R6

    AST_DONE_SAFE: assert property (@(posedge clk) disable iff (rst)
        (state_code == STAT_DONE) |-> (!hv_supply_en && !panel_rst_n)); // R8

    AST_STRAP_HELD: assert property (@(posedge clk) disable iff (rst)
        ((state != ST_OFF) && (state != ST_DONE) && ($past(state) != ST_OFF) &&
         ($past(state) != ST_DONE)) |-> $stable(ext_q)); // R10

    AST_ON_STATE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state_code == STAT_ON) |-> (!tx_valid && panel_rst_n)); // R7

endmodule

// File: tb/oled_pwr_seq_test.sv
module oled_pwr_seq_test;
    localparam int CLK_HZ    = 10_000;
    localparam int RESET_MS  = 10;
    localparam int SETTLE_MS = 100;
    localparam int COLUMNS   = 128;
    localparam int PAGES     = 8;
    localparam int TPM       = CLK_HZ / 1000;
    localparam int RST_T     = TPM * RESET_MS;
    localparam int SET_T     = TPM * SETTLE_MS;
    localparam int NCLR      = COLUMNS * PAGES;
    localparam int NUP       = 22 + 3 + NCLR + 1;

    localparam logic [7:0] CP_TAB [22] = '{8'hAE, 8'h00, 8'h10, 8'h40, 8'h81, 8'hCF, 8'hA1,
        8'hA6, 8'hA8, 8'h3F, 8'hD3, 8'h00, 8'hD5, 8'h80, 8'hD9, 8'hF1, 8'hDA, 8'h12, 8'hDB,
        8'h40, 8'h8D, 8'h14};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic power_up_req = 1'b0, power_down_req = 1'b0, ext_hv_mode = 1'b0;
    logic tx_ready = 1'b0;
    logic panel_rst_n, hv_supply_en, tx_valid, tx_is_data;
    logic [7:0] tx_byte;
    logic [1:0] state_code;

    oled_pwr_seq #(.CLK_HZ(CLK_HZ), .RESET_MS(RESET_MS), .SETTLE_MS(SETTLE_MS),
                   .COLUMNS(COLUMNS), .PAGES(PAGES)) uut (
        .clk(clk), .rst(rst), .power_up_req(power_up_req), .power_down_req(power_down_req),
        .ext_hv_mode(ext_hv_mode), .panel_rst_n(panel_rst_n), .hv_supply_en(hv_supply_en),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_byte(tx_byte), .tx_is_data(tx_is_data),
        .state_code(state_code));

    always #4 clk = ~clk;

    int n_tests = 0, n_fail = 0;
    int cyc = 0;
    int stall_hold = 0;
    bit finished = 0;

    logic [7:0] cap_b [2048];
    logic       cap_d [2048];
    int         cap_c [2048];
    logic       cap_h [2048];
    int cap_n = 0;
    int stall_viol = 0, tx_in_rst = 0;
    bit hv_seen = 0;
    int hv_rise = -1, hv_fall = -1, rst_rise = -1, done_cyc = -1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [8:0] exp_up(input int i, input bit ext);
        logic [7:0] b;
        if (i < 22) begin
            b = CP_TAB[i];
            if (ext && i == 5)  b = 8'h8F;
            if (ext && i == 15) b = 8'h22;
            if (ext && i == 21) b = 8'h10;
            return {1'b0, b};
        end
        if (i == 22) return 9'h000;
        if (i == 23) return 9'h010;
        if (i == 24) return 9'h0B0;
        if (i < 25 + NCLR) return 9'h100;
        return 9'h0AF;
    endfunction

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
        end
    end

    // transport model: random readiness with a fixed seed, plus forced stalls
    initial begin
        void'($urandom(32'd2718));
        forever begin
            @(posedge clk);
            #1;
            tx_ready = (stall_hold == 0) && (($urandom % 4) != 0);
            if (stall_hold > 0) stall_hold--;
        end
    end

    // monitor, sampled away from the rising edge
    initial begin
        bit   pend = 0;
        logic [7:0] pb = '0;
        logic pd = 0, ph = 0, pr = 0;
        logic [1:0] ps = '0;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (pend && (!tx_valid || tx_byte != pb || tx_is_data != pd)) stall_viol++;
                pend = tx_valid && !tx_ready;
                pb = tx_byte;
                pd = tx_is_data;
                if (tx_valid && !panel_rst_n) tx_in_rst++;
                if (tx_valid && tx_ready && cap_n < 2048) begin
                    cap_b[cap_n] = tx_byte;
                    cap_d[cap_n] = tx_is_data;
                    cap_c[cap_n] = cyc;
                    cap_h[cap_n] = hv_supply_en;
                    cap_n++;
                end
                if (hv_supply_en) hv_seen = 1;
                if (hv_supply_en && !ph) hv_rise = cyc;
                if (!hv_supply_en && ph) hv_fall = cyc;
                if (panel_rst_n && !pr) rst_rise = cyc;
                if (state_code == 2'd3 && ps != 2'd3) done_cyc = cyc;
                ph = hv_supply_en;
                pr = panel_rst_n;
                ps = state_code;
            end
        end
    end

    task automatic wait_status(input logic [1:0] s, input string req);
        int g = 0;
        while (state_code != s && g < 20000) begin
            @(negedge clk);
            g++;
        end
        chk(state_code == s, req, "state_code reached", state_code, s);
    endtask

    task automatic power_up(input bit ext, input bit disturb);
        int t0, bad_tab, bad_clr, bad_hv, c_last, c_on;
        ext_hv_mode = ext;
        cap_n = 0; hv_seen = 0; hv_rise = -1; rst_rise = -1;
        stall_viol = 0; tx_in_rst = 0;
        @(posedge clk); #1;
        power_up_req = 1'b1;
        t0 = cyc;
        @(posedge clk); #1;
        power_up_req = 1'b0;
        if (disturb) begin
            repeat (30) @(posedge clk);
            #1;
            ext_hv_mode = !ext;                  // R10: strap flips mid-sequence
            power_down_req = 1'b1;               // R9: shutdown while busy
            @(posedge clk); #1;
            power_down_req = 1'b0;
            while (cap_n < 300) @(posedge clk);
            #1;
            stall_hold = 25;                     // R5: long directed stall in the RAM pass
            power_up_req = 1'b1;                 // R9: power-up while busy
            @(posedge clk); #1;
            power_up_req = 1'b0;
        end
        wait_status(2'd2, "R7");
        chk(rst_rise - t0 == RST_T + 1, "R2", "reset release cycle", rst_rise - t0, RST_T + 1);
        chk(tx_in_rst == 0, "R2", "bytes offered during reset", tx_in_rst, 0);
        chk(cap_n == NUP, disturb ? "R9" : "R4", "bytes in power-up", cap_n, NUP);
        bad_tab = 0; bad_clr = 0; bad_hv = 0;
        for (int i = 0; i < NUP && i < cap_n; i++) begin
            if ({cap_d[i], cap_b[i]} != exp_up(i, ext)) begin
                if (i < 22) bad_tab++; else bad_clr++;
            end
            if (i < NUP - 1 && cap_h[i]) bad_hv++;
        end
        chk(bad_tab == 0, disturb ? "R10" : "R3", "table mismatches", bad_tab, 0);
        chk(bad_clr == 0, "R4", "addr/clear mismatches", bad_clr, 0);
        chk(stall_viol == 0, "R5", "stall hold violations", stall_viol, 0);
        chk(bad_hv == 0, "R6", "supply on before clear end", bad_hv, 0);
        if (cap_n == NUP) begin
            c_last = cap_c[NUP - 2];
            c_on = cap_c[NUP - 1];
            if (ext) begin
                chk(hv_rise - c_last == 1, "R6", "supply rise after last RAM byte", hv_rise - c_last, 1);
                chk(c_on - hv_rise >= SET_T, "R6", "settle before display-on", c_on - hv_rise, SET_T);
            end else begin
                chk(!hv_seen, "R6", "supply enable in pump mode", hv_seen, 0);
                chk(c_on - c_last >= SET_T + 1, "R6", "settle before display-on", c_on - c_last, SET_T + 1);
            end
        end
        @(negedge clk);
        chk(panel_rst_n == 1'b1 && hv_supply_en == ext, "R7", "on-state rst_n/hv",
            {panel_rst_n, hv_supply_en}, {1'b1, ext});
    endtask

    task automatic power_down(input bit ext);
        cap_n = 0; hv_fall = -1; done_cyc = -1;
        @(posedge clk); #1;
        power_down_req = 1'b1;
        @(posedge clk); #1;
        power_down_req = 1'b0;
        wait_status(2'd3, "R8");
        chk(cap_n == 1, "R8", "bytes in shutdown", cap_n, 1);
        chk({cap_d[0], cap_b[0]} == 9'h0AE, "R8", "display-off byte", {cap_d[0], cap_b[0]}, 9'h0AE);
        if (ext) chk(hv_fall - cap_c[0] == 1, "R8", "supply fall after AE", hv_fall - cap_c[0], 1);
        chk(done_cyc - cap_c[0] >= SET_T + 1, "R8", "discharge wait", done_cyc - cap_c[0], SET_T + 1);
        @(negedge clk);
        chk(!panel_rst_n && !hv_supply_en, "R8", "done-state rst_n/hv",
            {panel_rst_n, hv_supply_en}, 2'b00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(state_code == 2'd0, "R1", "reset state_code", state_code, 0);
        chk(!panel_rst_n && !hv_supply_en && !tx_valid, "R1", "reset outputs",
            {panel_rst_n, hv_supply_en, tx_valid}, 0);

        // R9: shutdown request in idle-off is ignored
        cap_n = 0;
        @(posedge clk); #1 power_down_req = 1'b1;
        @(posedge clk); #1 power_down_req = 1'b0;
        repeat (20) @(negedge clk);
        chk(state_code == 2'd0 && cap_n == 0, "R9", "idle after stray shutdown", state_code, 0);

        power_up(1'b0, 1'b1);

        // R9: power-up request while on is ignored
        cap_n = 0;
        @(posedge clk); #1 power_up_req = 1'b1;
        @(posedge clk); #1 power_up_req = 1'b0;
        repeat (50) @(negedge clk);
        chk(state_code == 2'd2 && cap_n == 0, "R9", "on after stray power-up", cap_n, 0);

        power_down(1'b0);
        power_up(1'b1, 1'b0);
        power_down(1'b1);
        power_up(1'b1, 1'b1);
        power_down(1'b1);

        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule